// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block models a 32-bit synchronous SRAM with a pipelined read path and a two-bit burst counter. Address, write data, the active-low select, the active-low address strobe and the write enables are all captured on the rising clock edge. Each captured cycle is either a read or a write of one to four byte lanes. A write applies to the array one clock later. A read returns its word from an output register one clock after the address was captured.

A burst opens when the strobe is sampled low while the device is selected. On each later edge with the strobe high, the low two address bits step through four offsets, in either linear or interleaved order. The output is a data bus plus a valid flag. The valid flag is gated without a clock by output enable and by a sleep input, and sleep also blocks any new array access.

Top module: `burst_sram`

## Requirements
- R1: A read (select low, strobe low, every byte enable high, global write high) captured at edge N drives `rdata_o` with the addressed word and raises `rvalid_o` after edge N+1.
- R2: A write updates byte lane i (bits 8i+7..8i) only when `lane_we_ni[i]` was sampled low. The other lanes keep their contents.
- R3: When `all_we_ni` is sampled low, all four lanes are written, whatever `lane_we_ni` holds.
- R4: A burst starts only on an edge with `stb_ni` and `cs_ni` both low. An edge with the strobe high while the device is deselected performs no access.
- R5: While the device is selected, each edge with `stb_ni` high performs a further access of the same kind at the next burst address. Address bits above the low two stay fixed.
- R6: With `order_i` = 0 at burst start, the low two address bits go start, start+1, start+2, start+3 modulo 4, and then repeat.
- R7: With `order_i` = 1 at burst start, the low two bits go start XOR 1, 2, 3, 0 in turn. The order is held for the whole burst, even if `order_i` later changes.
- R8: `oe_ni` high forces `rvalid_o` low at once, without a clock edge. Whenever `rvalid_o` is low, `rdata_o` is zero.
- R9: In the cycle after a write is captured, `rvalid_o` is low whatever the output enable is.
- R10: An edge with `cs_ni` high and `stb_ni` low deselects the device. `rvalid_o` is low after the following edge.
- R11: While `sleep_i` is high, `rvalid_o` is low at once, and no read or write is captured or applied to the array.
- R12: After reset, `rvalid_o` is low, `rdata_o` is zero and the device is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Word address captured at burst start |
| wdata_i | input | 32 | Write data |
| cs_ni | input | 1 | Active-low device select |
| stb_ni | input | 1 | Active-low address strobe |
| lane_we_ni | input | 4 | Active-low per-byte write enables |
| all_we_ni | input | 1 | Active-low write of all four lanes |
| oe_ni | input | 1 | Active-low output enable, unclocked |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep_i | input | 1 | Standby, unclocked gate on output and access |
| rdata_o | output | 32 | Read data, zero when not valid |
| rvalid_o | output | 1 | Read data valid |

## Verification
The hardest state to reach is a burst that wraps past its fourth beat with the mode input changed in the middle. Only a full run of strobe-high edges after a write-filled block shows whether the counter wraps and whether the order was held. The vector table first fills four words with a write burst. It then reads them back with a linear burst that runs five beats and an interleaved burst from an odd offset during which `order_i` is dropped. It ends with a partial-lane write followed at once by a read and a deselect. Directed steps then toggle output enable and sleep between edges to exercise the unclocked gating.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int LANE_W = 8;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } burst_ord_e;

    // Offset of burst beat 'step' from starting offset 'base'
    function automatic logic [1:0] burst_offset(input logic [1:0] base,
                                                input logic [1:0] step,
                                                input burst_ord_e ord);
        logic [1:0] r;
        case (ord)
            ORD_XOR: r = base ^ step;
            default: r = base + step;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              cs_ni,
    input  logic              stb_ni,
    input  logic [LANES-1:0]  lane_we_ni,
    input  logic              all_we_ni,
    input  logic              order_i,
    input  logic              sleep_i,
    output logic              acc_rd_o,
    output logic              acc_wr_o,
    output logic [LANES-1:0]  acc_be_o,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic [DATA_W-1:0] acc_wdata_o
);

    typedef struct packed {
        logic              sel;
        logic [ADDR_W-1:0] base;
        logic [1:0]        step;
        burst_ord_e        ord;
        logic              acc_rd;
        logic              acc_wr;
        logic [LANES-1:0]  acc_be;
        logic [ADDR_W-1:0] acc_addr;
        logic [DATA_W-1:0] acc_wdata;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic              open_burst, drop_sel, next_beat, do_acc;
    logic [LANES-1:0]  wr_lanes;
    logic [ADDR_W-1:0] beat_addr;
    logic [1:0]        next_step;

    always_comb begin
        st_d        = st_q;
        st_d.acc_rd = 1'b0;
        st_d.acc_wr = 1'b0;
        st_d.acc_be = '0;

        open_burst = !cs_ni && !stb_ni;
        drop_sel   = cs_ni && !stb_ni;
        next_beat  = stb_ni && st_q.sel;
        wr_lanes   = all_we_ni ? ~lane_we_ni : '1;
        next_step  = st_q.step + 2'd1;
        beat_addr  = {st_q.base[ADDR_W-1:2],
                      burst_offset(st_q.base[1:0], next_step, st_q.ord)};
        do_acc     = 1'b0;

        if (!sleep_i) begin
            if (open_burst) begin
                st_d.sel      = 1'b1;
                st_d.base     = addr_i;
                st_d.step     = 2'd0;
                st_d.ord      = burst_ord_e'(order_i);
                st_d.acc_addr = addr_i;
                do_acc        = 1'b1;
            end else if (drop_sel) begin
                st_d.sel = 1'b0;
            end else if (next_beat) begin
                st_d.step     = next_step;
                st_d.acc_addr = beat_addr;
                do_acc        = 1'b1;
            end
            if (do_acc) begin
                st_d.acc_wr    = |wr_lanes;
                st_d.acc_rd    = ~|wr_lanes;
                st_d.acc_be    = wr_lanes;
                st_d.acc_wdata = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_rd_o    = st_q.acc_rd;
    assign acc_wr_o    = st_q.acc_wr;
    assign acc_be_o    = st_q.acc_be;
    assign acc_addr_o  = st_q.acc_addr;
    assign acc_wdata_o = st_q.acc_wdata;

endmodule

// File: rtl/sram_array.sv
module sram_array
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sleep_i,
    input  logic              acc_rd_i,
    input  logic              acc_wr_i,
    input  logic [LANES-1:0]  acc_be_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [DATA_W-1:0] acc_wdata_i,
    output logic              rd_pend_o,
    output logic [DATA_W-1:0] rd_data_o
);

    typedef struct packed {
        logic              pend;
        logic [DATA_W-1:0] data;
    } rd_st_t;

    rd_st_t            rd_d, rd_q;
    logic [DATA_W-1:0] word_rd;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk_i) begin
            if (acc_wr_i && acc_be_i[l] && !sleep_i) begin
                lane_mem[acc_addr_i] <= acc_wdata_i[l*LANE_W +: LANE_W];
            end
        end

        assign word_rd[l*LANE_W +: LANE_W] = lane_mem[acc_addr_i];
    end

    always_comb begin
        rd_d      = rd_q;
        rd_d.pend = acc_rd_i && !sleep_i;
        if (rd_d.pend) begin
            rd_d.data = word_rd;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_pend_o = rd_q.pend;
    assign rd_data_o = rd_q.data;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              cs_ni,
    input  logic              stb_ni,
    input  logic [LANES-1:0]  lane_we_ni,
    input  logic              all_we_ni,
    input  logic              oe_ni,
    input  logic              order_i,
    input  logic              sleep_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    logic              acc_rd, acc_wr, rd_pend;
    logic [LANES-1:0]  acc_be;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wdata, rd_data;

    burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .cs_ni       (cs_ni),
        .stb_ni      (stb_ni),
        .lane_we_ni  (lane_we_ni),
        .all_we_ni   (all_we_ni),
        .order_i     (order_i),
        .sleep_i     (sleep_i),
        .acc_rd_o    (acc_rd),
        .acc_wr_o    (acc_wr),
        .acc_be_o    (acc_be),
        .acc_addr_o  (acc_addr),
        .acc_wdata_o (acc_wdata)
    );

    sram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sleep_i     (sleep_i),
        .acc_rd_i    (acc_rd),
        .acc_wr_i    (acc_wr),
        .acc_be_i    (acc_be),
        .acc_addr_i  (acc_addr),
        .acc_wdata_i (acc_wdata),
        .rd_pend_o   (rd_pend),
        .rd_data_o   (rd_data)
    );

    // Unclocked output gating: enable, standby, and a write just captured
    assign rvalid_o = rd_pend && !acc_wr && !oe_ni && !sleep_i;
    assign rdata_o  = rvalid_o ? rd_data : '0;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cs_ni,
    input logic              stb_ni,
    input logic              all_we_ni,
    input logic              oe_ni,
    input logic              sleep_i,
    input logic              rvalid_o,
    input logic              acc_rd,
    input logic              acc_wr,
    input logic [ADDR_W-1:0] acc_addr
);

    logic [1:0] since_rst;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    AST_OE_BLOCKS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oe_ni |-> !rvalid_o); // R8

    AST_SLEEP_BLOCKS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sleep_i |-> !rvalid_o); // R11

    AST_SLEEP_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sleep_i |=> !(acc_rd || acc_wr)); // R11

    AST_WRITE_HIDES_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cs_ni && !stb_ni && !sleep_i && !all_we_ni) |=> !rvalid_o); // R9

    AST_DESELECT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst >= 2'd2 && $past(cs_ni && !stb_ni && !sleep_i, 2)) |-> !rvalid_o); // R10

    AST_BURST_STEP_IN_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst >= 2'd2 && $past(!cs_ni && !stb_ni && !sleep_i, 2)
         && $past(stb_ni && !sleep_i, 1))
        |-> (acc_rd || acc_wr)
            && acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])
            && acc_addr[1:0] != $past(acc_addr[1:0])); // R5

endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .stb_ni    (stb_ni),
    .all_we_ni (all_we_ni),
    .oe_ni     (oe_ni),
    .sleep_i   (sleep_i),
    .rvalid_o  (rvalid_o),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr)
);

// File: tb/burst_sram_test.sv
`timescale 1ns/1ps
module burst_sram_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        cs_n = 1'b1, stb_n = 1'b1, gw_n = 1'b1, oe_n = 1'b0;
    logic        ord = 1'b0, sleep = 1'b0;
    logic [3:0]  be_n = 4'hF;
    logic [31:0] rdata;
    logic        rvalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_sram uut (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
        .cs_ni(cs_n), .stb_ni(stb_n), .lane_we_ni(be_n), .all_we_ni(gw_n),
        .oe_ni(oe_n), .order_i(ord), .sleep_i(sleep),
        .rdata_o(rdata), .rvalid_o(rvalid)
    );

    typedef struct packed {
        logic        cs_n;
        logic        stb_n;
        logic [3:0]  be_n;
        logic        gw_n;
        logic        ord;
        logic [5:0]  addr;
        logic [31:0] wd;
        logic        ev;
        logic [31:0] ed;
        logic [3:0]  req;
    } row_t;

    // Expected outputs are those seen just after the row's own edge,
    // i.e. the result of the read captured by the previous row.
    localparam row_t TBL [19] = '{
        '{1'b0,1'b0,4'hF,1'b0,1'b0,6'd8, 32'hC0DE0008,1'b0,32'h0,4'd3},        // R3 global write @8
        '{1'b0,1'b1,4'h0,1'b1,1'b0,6'd0, 32'hC0DE0009,1'b0,32'h0,4'd2},        // R2 beat -> 9
        '{1'b0,1'b1,4'h0,1'b1,1'b0,6'd0, 32'hC0DE000A,1'b0,32'h0,4'd5},        // R5 beat -> 10
        '{1'b0,1'b1,4'h0,1'b1,1'b0,6'd0, 32'hC0DE000B,1'b0,32'h0,4'd5},        // R5 beat -> 11
        '{1'b0,1'b0,4'hF,1'b1,1'b0,6'd10,32'h0,       1'b0,32'h0,4'd1},        // R1 linear read @10
        '{1'b0,1'b1,4'hF,1'b1,1'b0,6'd0, 32'h0,       1'b1,32'hC0DE000A,4'd1}, // R1 -> 11
        '{1'b0,1'b1,4'hF,1'b1,1'b0,6'd0, 32'h0,       1'b1,32'hC0DE000B,4'd6}, // R6 -> 8
        '{1'b0,1'b1,4'hF,1'b1,1'b0,6'd0, 32'h0,       1'b1,32'hC0DE0008,4'd6}, // R6 -> 9
        '{1'b0,1'b1,4'hF,1'b1,1'b0,6'd0, 32'h0,       1'b1,32'hC0DE0009,4'd6}, // R6 wrap -> 10
        '{1'b0,1'b0,4'hF,1'b1,1'b1,6'd9, 32'h0,       1'b1,32'hC0DE000A,4'd6}, // R7 xor read @9
        '{1'b0,1'b1,4'hF,1'b1,1'b0,6'd0, 32'h0,       1'b1,32'hC0DE0009,4'd7}, // R7 -> 8, mode dropped
        '{1'b0,1'b1,4'hF,1'b1,1'b0,6'd0, 32'h0,       1'b1,32'hC0DE0008,4'd7}, // R7 -> 11
        '{1'b0,1'b1,4'hF,1'b1,1'b0,6'd0, 32'h0,       1'b1,32'hC0DE000B,4'd7}, // R7 -> 10
        '{1'b0,1'b0,4'hA,1'b1,1'b0,6'd8, 32'h55667788,1'b0,32'h0,4'd9},        // R9 lanes 0,2 @8
        '{1'b0,1'b0,4'hF,1'b1,1'b0,6'd8, 32'h0,       1'b0,32'h0,4'd2},        // R2 read @8
        '{1'b1,1'b0,4'hF,1'b1,1'b0,6'd0, 32'h0,       1'b1,32'hC0660088,4'd2}, // R2 merged lanes
        '{1'b1,1'b1,4'hF,1'b1,1'b0,6'd0, 32'h0,       1'b0,32'h0,4'd10},       // R10 deselected
        '{1'b0,1'b1,4'hF,1'b1,1'b0,6'd0, 32'h0,       1'b0,32'h0,4'd4},        // R4 strobe high, idle
        '{1'b1,1'b1,4'hF,1'b1,1'b0,6'd0, 32'h0,       1'b0,32'h0,4'd4}         // R4 nothing was read
    };

    task automatic chk(input string tag, input logic v, input logic [31:0] d,
                       input logic ev, input logic [31:0] ed);
        checks++;
        if (v !== ev || d !== ed) begin
            errors++;
            $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                     tag, v, d, ev, ed);
        end
    endtask

    task automatic drive(input logic c, input logic s, input logic [3:0] b,
                         input logic g, input logic [5:0] a, input logic [31:0] w);
        cs_n = c; stb_n = s; be_n = b; gw_n = g; addr = a; wdata = w;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset state", rvalid, rdata, 1'b0, 32'h0);

        for (int i = 0; i < 19; i++) begin
            drive(TBL[i].cs_n, TBL[i].stb_n, TBL[i].be_n, TBL[i].gw_n,
                  TBL[i].addr, TBL[i].wd);
            ord = TBL[i].ord;
            tick();
            chk($sformatf("R%0d row %0d", TBL[i].req, i), rvalid, rdata,
                TBL[i].ev, TBL[i].ed);
        end

        // R8: output enable gates the flag without a clock edge
        drive(1'b0, 1'b0, 4'hF, 1'b1, 6'd9, 32'h0);
        tick();
        drive(1'b1, 1'b0, 4'hF, 1'b1, 6'd0, 32'h0);
        oe_n = 1'b1;
        tick();
        chk("R8 oe high", rvalid, rdata, 1'b0, 32'h0);
        oe_n = 1'b0;
        #1;
        chk("R8 oe low", rvalid, rdata, 1'b1, 32'hC0DE0009);
        drive(1'b1, 1'b1, 4'hF, 1'b1, 6'd0, 32'h0);
        tick();
        chk("R10 after deselect", rvalid, rdata, 1'b0, 32'h0);

        // R11: write attempted in standby leaves the array unchanged
        sleep = 1'b1;
        drive(1'b0, 1'b0, 4'hF, 1'b0, 6'd9, 32'hDEADBEEF);
        tick();
        drive(1'b1, 1'b0, 4'hF, 1'b1, 6'd0, 32'h0);
        tick();
        sleep = 1'b0;
        drive(1'b0, 1'b0, 4'hF, 1'b1, 6'd9, 32'h0);
        tick();
        drive(1'b1, 1'b0, 4'hF, 1'b1, 6'd0, 32'h0);
        tick();
        chk("R11 no write in standby", rvalid, rdata, 1'b1, 32'hC0DE0009);

        // R11: standby hides a pending read at once
        drive(1'b0, 1'b0, 4'hF, 1'b1, 6'd11, 32'h0);
        tick();
        drive(1'b1, 1'b0, 4'hF, 1'b1, 6'd0, 32'h0);
        tick();
        sleep = 1'b1;
        #1;
        chk("R11 standby gates flag", rvalid, rdata, 1'b0, 32'h0);
        sleep = 1'b0;
        #1;
        chk("R11 standby released", rvalid, rdata, 1'b1, 32'hC0DE000B);

        // R12: reset mid-activity returns to idle
        drive(1'b0, 1'b0, 4'hF, 1'b1, 6'd8, 32'h0);
        tick();
        rst_n = 1'b0;
        drive(1'b1, 1'b1, 4'hF, 1'b1, 6'd0, 32'h0);
        tick();
        chk("R12 reset clears output", rvalid, rdata, 1'b0, 32'h0);
        rst_n = 1'b1;
        drive(1'b0, 1'b1, 4'hF, 1'b1, 6'd0, 32'h0);
        tick();
        tick();
        chk("R12 deselected after reset", rvalid, rdata, 1'b0, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule